// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block sits beside a bus-master DMA engine and turns a table of scatter-gather descriptors in system memory into a stream of transfer segments. Software places the table at a base pointer. Each entry is eight bytes long and names a buffer address and a byte count. The engine asks for a number of bytes. The walker reads descriptors one at a time through a simple request/response memory port. It then hands address/length pairs to a data mover until the request is met or the table runs out.

A request may end in the middle of a descriptor. The unused part of that descriptor is kept, and the next request carries on from it. A restart puts the walk back at the first entry of the table. Two conditions end a walk: a descriptor flagged as final, or a fetch pointer that has moved one page or more past the base. When the table ends before the request is met, the walker raises a short-table indication together with its completion pulse. The data transfer itself and the bus arbitration are done elsewhere.

Top module: `sgw_table_walker`

## Requirements
- R1: A fetched descriptor is decoded as follows. rd_data[31:0] is the buffer address. rd_data[47:32] is the byte count, with bit 32 forced to zero. rd_data[63] is the final-entry flag.
- R2: A decoded byte count of zero stands for 65536 bytes.
- R3: The fetches after a restart go to base, base+8, base+16, and so on. The pointer advances by 8 on every accepted descriptor.
- R4: Each segment length is the smaller of the bytes still requested and the bytes left in the current descriptor. The segment length is never zero and never above 65536. After the handshake, the descriptor address moves up by the segment length and the descriptor's remaining count moves down by it.
- R5: When a request finishes partway through a descriptor, the next request first uses the rest of that descriptor and does not fetch it again.
- R6: Suppose bytes are still requested, the current descriptor is used up, and it carried the final flag. The walker then fetches nothing more. It ends the request with done and short_tbl both high. short_tbl is never high without done.
- R7: No fetch is issued once the fetch pointer is 4096 or more bytes past the base. Reaching that point with bytes still requested ends the request as short.
- R8: restart (sampled in idle) loads the fetch pointer from base_addr and discards any leftover descriptor state and final flag.
- R9: At most one descriptor read is outstanding. rd_req stays high with a stable rd_addr until rd_valid, and drops the cycle after. rd_req and seg_valid are never high together.
- R10: seg_valid stays high with stable seg_addr and seg_len until seg_ready.
- R11: Each start (sampled in idle) produces exactly one single-cycle done pulse. A request for zero bytes completes with no fetch, no segment and no short indication.
- R12: After reset, rd_req, seg_valid, done, short_tbl and tbl_end are all low.
- R13: tbl_end is high exactly when the current descriptor is used up and either the final flag was seen or the page limit is reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | PTR_W | Table base pointer, taken on restart |
| restart | input | 1 | Rewind the walk to the table base (idle only) |
| start | input | 1 | Begin a request of req_bytes (idle only) |
| req_bytes | input | CNT_W | Number of bytes requested |
| rd_req | output | 1 | Descriptor read request, held until rd_valid |
| rd_addr | output | PTR_W | Address of the descriptor being read |
| rd_valid | input | 1 | Descriptor read data is valid |
| rd_data | input | 64 | Descriptor contents, first word in the low half |
| seg_valid | output | 1 | A transfer segment is offered |
| seg_ready | input | 1 | Data mover takes the segment |
| seg_addr | output | 32 | Segment buffer address |
| seg_len | output | 17 | Segment length in bytes |
| done | output | 1 | Single-cycle request completion pulse |
| short_tbl | output | 1 | With done: the table ended before the request was met |
| tbl_end | output | 1 | Table is exhausted at the current position |

## Verification
The bench aims at the length field edges: a count with bit 0 set, which a design that does not mask it would turn into an odd segment, and a zero count, which a design without the 64 KiB rule would skip or hang on. It splits requests across descriptor boundaries and ends them partway through a descriptor. A design that drops the leftover state would fetch the same entry again or lose bytes, and one that does not take the minimum would emit oversize segments. It runs a table with no final flag past 512 entries to catch a fence on the page limit that is missing or off by one. It also checks that a restart after a partial walk really rewinds, rather than carrying on from the stale pointer.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  localparam int DESC_BYTES = 8;
  localparam int LEN_W      = 17;
  localparam int BUF_AW     = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_FETCH = 2'd2,
    ST_SEG   = 2'd3
  } walk_state_e;

  typedef struct packed {
    logic              fin;
    logic [LEN_W-1:0]  len;
    logic [BUF_AW-1:0] addr;
  } desc_t;

  // Byte count field: bit 0 dropped, zero means a full 64 KiB.
  function automatic logic [LEN_W-1:0] count_from_field(input logic [15:0] field);
    logic [15:0] even;
    even = field & 16'hFFFE;
    if (even == 16'h0000) return 17'h10000;
    return {1'b0, even};
  endfunction

endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
(
  input  logic [63:0] raw,
  output desc_t       desc
);
  always_comb begin
    desc.addr = raw[31:0];
    desc.len  = count_from_field(raw[47:32]);
    desc.fin  = raw[63];
  end
endmodule

// File: rtl/sgw_limit_check.sv
module sgw_limit_check #(
  parameter int PTR_W      = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic [PTR_W-1:0] base,
  input  logic             desc_empty,
  input  logic             fin_seen,
  output logic             past_page,
  output logic             exhausted
);
  localparam logic [PTR_W-1:0] PAGE_SPAN = PTR_W'(PAGE_BYTES);
  logic [PTR_W-1:0] span;
  always_comb begin
    span      = ptr - base;
    past_page = (span >= PAGE_SPAN);
    exhausted = desc_empty && (fin_seen || past_page);
  end
endmodule

// File: rtl/sgw_seg_size.sv
module sgw_seg_size
  import sgw_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic [CNT_W-1:0] want,
  input  logic [LEN_W-1:0] avail,
  output logic [LEN_W-1:0] seg
);
  always_comb begin
    if (want > CNT_W'(avail)) seg = avail;
    else                      seg = want[LEN_W-1:0];
  end
endmodule

// File: rtl/sgw_table_walker.sv
module sgw_table_walker
  import sgw_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int CNT_W      = 24,
  parameter int PAGE_BYTES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] base_addr,
  input  logic             restart,
  input  logic             start,
  input  logic [CNT_W-1:0] req_bytes,
  output logic             rd_req,
  output logic [PTR_W-1:0] rd_addr,
  input  logic             rd_valid,
  input  logic [63:0]      rd_data,
  output logic             seg_valid,
  input  logic             seg_ready,
  output logic [31:0]      seg_addr,
  output logic [16:0]      seg_len,
  output logic             done,
  output logic             short_tbl,
  output logic             tbl_end
);
  localparam logic [PTR_W-1:0] PTR_STEP = PTR_W'(DESC_BYTES);

  walk_state_e       state_q;
  logic [PTR_W-1:0]  ptr_q, base_q;
  logic [CNT_W-1:0]  rem_q;
  logic [LEN_W-1:0]  dlen_q;
  logic [BUF_AW-1:0] daddr_q;
  logic              dfin_q;
  logic              done_q, short_q;

  desc_t             fetched;
  logic [LEN_W-1:0]  seg_n;
  logic              past_page, exhausted;

  // Named internal events
  logic ev_rd_accept, ev_seg_accept, ev_finish, ev_need_fetch, ev_issue, ev_short;

  sgw_desc_decode u_dec (.raw(rd_data), .desc(fetched));

  sgw_limit_check #(.PTR_W(PTR_W), .PAGE_BYTES(PAGE_BYTES)) u_lim (
    .ptr(ptr_q), .base(base_q), .desc_empty(dlen_q == '0), .fin_seen(dfin_q),
    .past_page(past_page), .exhausted(exhausted)
  );

  sgw_seg_size #(.CNT_W(CNT_W)) u_seg (.want(rem_q), .avail(dlen_q), .seg(seg_n));

  always_comb begin
    ev_rd_accept  = (state_q == ST_FETCH) && rd_valid;
    ev_seg_accept = (state_q == ST_SEG) && seg_ready;
    ev_short      = (state_q == ST_EVAL) && (rem_q != '0) && exhausted;
    ev_finish     = (state_q == ST_EVAL) && ((rem_q == '0) || exhausted);
    ev_need_fetch = (state_q == ST_EVAL) && (rem_q != '0) && (dlen_q == '0) && !exhausted;
    ev_issue      = (state_q == ST_EVAL) && (rem_q != '0) && (dlen_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      base_q  <= '0;
      rem_q   <= '0;
      dlen_q  <= '0;
      daddr_q <= '0;
      dfin_q  <= 1'b0;
      done_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      done_q  <= ev_finish;
      short_q <= ev_short;
      unique case (state_q)
        ST_IDLE: begin
          if (restart) begin
            ptr_q  <= base_addr;
            base_q <= base_addr;
            dlen_q <= '0;
            dfin_q <= 1'b0;
          end
          if (start) begin
            rem_q   <= req_bytes;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (ev_finish)          state_q <= ST_IDLE;
          else if (ev_need_fetch) state_q <= ST_FETCH;
          else if (ev_issue)      state_q <= ST_SEG;
        end
        ST_FETCH: begin
          if (ev_rd_accept) begin
            ptr_q   <= ptr_q + PTR_STEP;
            daddr_q <= fetched.addr;
            dlen_q  <= fetched.len;
            dfin_q  <= fetched.fin;
            state_q <= ST_EVAL;
          end
        end
        ST_SEG: begin
          if (ev_seg_accept) begin
            daddr_q <= daddr_q + BUF_AW'(seg_n);
            dlen_q  <= dlen_q - seg_n;
            rem_q   <= rem_q - CNT_W'(seg_n);
            state_q <= ST_EVAL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req    = (state_q == ST_FETCH);
  assign rd_addr   = ptr_q;
  assign seg_valid = (state_q == ST_SEG);
  assign seg_addr  = daddr_q;
  assign seg_len   = seg_n;
  assign done      = done_q;
  assign short_tbl = short_q;
  assign tbl_end   = exhausted;

endmodule

// File: rtl/sgw_table_walker_chk.sv
module sgw_table_walker_chk #(
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic [PTR_W-1:0] rd_addr,
  input logic             rd_valid,
  input logic             seg_valid,
  input logic             seg_ready,
  input logic [31:0]      seg_addr,
  input logic [16:0]      seg_len,
  input logic             done,
  input logic             short_tbl,
  input logic             tbl_end,
  input logic             ev_rd_accept
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R9
  AST_RD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_accept |=> !rd_req); // R9
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && seg_valid)); // R9
  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len)); // R10
  AST_SEG_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != 17'd0) && (seg_len <= 17'h10000)); // R4
  AST_SHORT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    short_tbl |-> done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_NO_FETCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_end |-> !rd_req); // R7
endmodule

bind sgw_table_walker sgw_table_walker_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
  .done(done), .short_tbl(short_tbl), .tbl_end(tbl_end), .ev_rd_accept(ev_rd_accept)
);

// File: tb/sgw_table_walker_bench.sv
`timescale 1ns/1ps
module sgw_table_walker_bench;
  localparam int PTR_W = 32;
  localparam int CNT_W = 24;
  localparam logic [31:0] TB = 32'h0001_0000;
  localparam int NDESC = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PTR_W-1:0] base_addr = TB;
  logic restart = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] req_bytes = '0;
  logic rd_req, rd_valid = 1'b0;
  logic [PTR_W-1:0] rd_addr;
  logic [63:0] rd_data = '0;
  logic seg_valid, seg_ready = 1'b0;
  logic [31:0] seg_addr;
  logic [16:0] seg_len;
  logic done, short_tbl, tbl_end;

  always #2.5 clk = ~clk;

  sgw_table_walker #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_sgw_table_walker (.*);

  int errors = 0, checks = 0;
  int n_fetch = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Memory image of the table
  logic [31:0] mem_a [NDESC];
  logic [31:0] mem_c [NDESC];

  // Behavioural reference model
  logic [31:0] m_ptr, m_base, m_addr;
  int          m_len;
  bit          m_last;
  bit          exp_short;
  logic [31:0] q_fetch[$];
  logic [31:0] q_sa[$];
  int          q_sl[$];

  function automatic bit m_at_end();
    return (m_len == 0) && (m_last || ((m_ptr - m_base) >= 32'd4096));
  endfunction

  task automatic plan(input int bytes);
    int rem;
    rem = bytes;
    while (rem > 0) begin
      if (m_len == 0) begin
        int idx;
        if (m_at_end()) break;
        idx = int'((m_ptr - TB) >> 3);
        q_fetch.push_back(m_ptr);
        m_addr = mem_a[idx];
        m_len  = int'(mem_c[idx][15:0]) & 32'hFFFE;
        if (m_len == 0) m_len = 65536;
        m_last = mem_c[idx][31];
        m_ptr  = m_ptr + 8;
      end
      begin
        int n;
        n = (rem < m_len) ? rem : m_len;
        q_sa.push_back(m_addr);
        q_sl.push_back(n);
        m_addr = m_addr + n;
        m_len  = m_len - n;
        rem    = rem - n;
      end
    end
    exp_short = (rem > 0);
  endtask

  // Memory responder with varying latency; compares every clock
  int rlat = 0, rseed = 0;
  logic [31:0] held_ra;
  bit          r_wait = 0;
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_valid = 1'b0;
      r_wait = 0;
    end else if (rd_req) begin
      if (r_wait)
        check(rd_addr == held_ra, "R9", "read address held", rd_addr, held_ra);
      else begin
        r_wait = 1; held_ra = rd_addr; rlat = rseed % 3; rseed++;
      end
      if (rlat == 0) begin
        int idx;
        n_fetch++;
        if (q_fetch.size() == 0)
          check(0, "R3", "unexpected fetch", rd_addr, 0);
        else begin
          logic [31:0] e;
          e = q_fetch.pop_front();
          check(rd_addr == e, "R3", "fetch address", rd_addr, e);
        end
        idx = int'((rd_addr - TB) >> 3);
        if (idx >= 0 && idx < NDESC) rd_data = {mem_c[idx], mem_a[idx]};
        else rd_data = '0;
        rd_valid = 1'b1;
      end else rlat--;
    end
  end

  // Data mover model
  int slat = 0, sseed = 0;
  logic [31:0] held_sa; logic [16:0] held_sl;
  bit s_wait = 0;
  always @(negedge clk) begin
    if (seg_ready) begin
      seg_ready = 1'b0;
      s_wait = 0;
    end else if (seg_valid) begin
      if (s_wait)
        check(seg_addr == held_sa && seg_len == held_sl, "R10", "segment held",
              {seg_addr, 15'd0, seg_len}, {held_sa, 15'd0, held_sl});
      else begin
        s_wait = 1; held_sa = seg_addr; held_sl = seg_len; slat = (sseed * 7) % 4; sseed++;
      end
      if (slat == 0) begin
        if (q_sa.size() == 0)
          check(0, "R4", "unexpected segment", seg_len, 0);
        else begin
          logic [31:0] ea; int el;
          ea = q_sa.pop_front(); el = q_sl.pop_front();
          check(seg_addr == ea, "R4", "segment address", seg_addr, ea);
          check(int'(seg_len) == el, "R4", "segment length", seg_len, el);
        end
        seg_ready = 1'b1;
      end else slat--;
    end
  end

  task automatic do_restart(input logic [31:0] b);
    @(negedge clk);
    restart = 1'b1; base_addr = b;
    m_ptr = b; m_base = b; m_len = 0; m_last = 0;
    @(negedge clk);
    restart = 1'b0;
    check(tbl_end == 1'b0, "R13", "tbl_end after restart", tbl_end, 0);
  endtask

  task automatic run_req(input int bytes, input string tag);
    int guard;
    plan(bytes);
    @(negedge clk);
    start = 1'b1; req_bytes = CNT_W'(bytes);
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (done || guard > 40000) break;
    end
    check(done == 1'b1, "R11", {tag, " done seen"}, done, 1);
    check(short_tbl == exp_short, "R6", {tag, " short indication"}, short_tbl, exp_short);
    check(q_fetch.size() == 0, "R3", {tag, " fetches left"}, q_fetch.size(), 0);
    check(q_sa.size() == 0, "R4", {tag, " segments left"}, q_sa.size(), 0);
    check(tbl_end == m_at_end(), "R13", {tag, " tbl_end"}, tbl_end, m_at_end());
    @(negedge clk);
    check(done == 1'b0, "R11", {tag, " done single cycle"}, done, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int f0;
    for (int i = 0; i < NDESC; i++) begin mem_a[i] = 32'h0; mem_c[i] = 32'h2; end
    mem_a[0] = 32'h0000_1000; mem_c[0] = 32'h0000_0200;
    mem_a[1] = 32'h0000_8000; mem_c[1] = 32'h0000_0101; // bit 0 set: masked (R1)
    mem_a[2] = 32'h0002_0000; mem_c[2] = 32'h8000_0000; // zero count, final (R2)
    m_ptr = TB; m_base = TB; m_len = 0; m_last = 0;
    repeat (3) @(negedge clk);
    check(rd_req == 0 && seg_valid == 0 && done == 0 && short_tbl == 0 && tbl_end == 0,
          "R12", "reset outputs", {rd_req, seg_valid, done, short_tbl, tbl_end}, 0);
    rst_n = 1'b1;
    do_restart(TB);

    run_req(32'h80, "R4 partial first descriptor");
    f0 = n_fetch;
    run_req(32'h100, "R5 leftover");
    check(n_fetch == f0, "R5", "no refetch of leftover", n_fetch - f0, 0);
    run_req(32'h100, "R1 masked count");
    run_req(32'h10080, "R2 full 64KiB");
    check(tbl_end == 1'b1, "R13", "end after final entry", tbl_end, 1);
    f0 = n_fetch;
    run_req(32'h40, "R6 past final");
    check(n_fetch == f0, "R6", "no fetch after final", n_fetch - f0, 0);
    f0 = n_fetch;
    run_req(0, "R11 zero bytes");
    check(n_fetch == f0, "R11", "zero request fetches nothing", n_fetch - f0, 0);

    do_restart(TB);
    run_req(32'h10, "R8 rewind");
    do_restart(TB);
    run_req(32'h201, "R8 leftover discarded");
    run_req(3, "odd split");

    for (int i = 0; i < NDESC; i++) begin mem_a[i] = 32'h0040_0000 + i * 16; mem_c[i] = 32'h2; end
    do_restart(TB);
    f0 = n_fetch;
    run_req(2000, "R7 page limit");
    check(n_fetch - f0 == 512, "R7", "fetches before page fence", n_fetch - f0, 512);
    check(short_tbl == 0, "R6", "short cleared after pulse", short_tbl, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule